// File: doc/BRIEF.md
# Multithreaded Fetch Line Manager

This block sits in a multithreaded fetch stage. It keeps one buffered instruction-cache line per hardware thread. Each cycle a thread is chosen for fetch, and the block aligns that thread's fetch address down to a cache-block boundary. If the thread's buffered line is valid and its stored block address matches, no memory traffic is needed. The block cuts a group of fixed-size instructions out of the line and registers them into a slot array bound for decode. On a miss, the block raises a line read toward the instruction cache on a valid/ready handshake. Each read carries a tag taken from a running sequence counter. The single-beat response returns the whole line together with that tag.

The cache may refuse a read. The refused read is then parked in one retry slot that is shared by all threads, and a global blocked flag stops every thread from starting new fetches. A retry pulse from the cache resends the parked read. A response that no longer belongs to the thread's outstanding read is counted and thrown away. Three inputs stand in for neighbouring logic: a translation fault, a per-instruction predicted-taken flag, and a per-instruction quiesce marker. A fault produces a single fault-carrying no-op and parks the thread until it is squashed.

Each thread runs a small state machine. TS_RUN is the state in which a thread may fetch. TS_WAIT_RETRY means its read sits in the retry slot. TS_WAIT_RESP means a read was accepted and its line is awaited. TS_TRAP means a fault was reported. The transitions are:
- issue: TS_RUN to TS_WAIT_RESP, when a read is accepted.
- park: TS_RUN to TS_WAIT_RETRY, when a read is refused.
- resend: TS_WAIT_RETRY to TS_WAIT_RESP, when a retry is accepted.
- fill: TS_WAIT_RESP to TS_RUN, when a matching response arrives.
- fault: TS_RUN to TS_TRAP.
- squash: any state to TS_RUN.

Top module: `fetch_line_unit`

## Requirements
- R1: The read address `req_addr` for a new miss equals `fetch_pc` with its low log2(BLK_BYTES) bits cleared (0x0104 reads 0x0100 with 16-byte blocks).
- R2: When the fetching thread's buffered line is valid and its block address equals the aligned PC, no read is raised. The extracted instructions appear on the slot outputs on the clock edge that ends the fetch cycle.
- R3: A miss raises `req_valid` combinationally in the same cycle as the fetch. Once the read is accepted, the thread's line is invalid and the thread raises no further read until the response arrives or the thread is squashed.
- R4: A read refused by the cache (`req_ready` low) is parked with its thread number, address and tag. `cache_blocked` is 1 from the next edge onward.
- R5: On `retry_pulse`, a parked read is driven again with the same address, thread and tag. If it is accepted, `cache_blocked` clears at the next edge. If the slot is empty, the pulse only clears `cache_blocked`.
- R6: A response is dropped and `drop_cnt` increases by exactly one when its thread is not in TS_WAIT_RESP or when its tag differs from that thread's outstanding tag.
- R7: No fetch, hit or miss, is started while `cache_blocked` is 1. No fetch is started while `intr_pending` is 1 and `fetch_pc[1:0]` is 00. In both cases no read is raised and no slot is valid.
- R8: Instruction j of a line occupies bits [j*INST_W +: INST_W], and output slot k occupies `out_inst[k*INST_W +: INST_W]`. Extraction starts at index `fetch_pc[OFF_W-1:IB_W]`. It stops at FETCH_W instructions, at the end of the line, or after an instruction whose `pred_taken` or `quiesce` bit is set. Valid slots are contiguous from slot 0, and `out_count` equals their number.
- R9: A miss with `xlate_fault` high raises no read. It produces exactly one valid slot holding all zeros with `out_fault` = 1, and the thread starts nothing more until squashed.
- R10: A squash of a thread returns it to TS_RUN, forgets its outstanding read so that the late response is dropped, and empties the retry slot if that slot belongs to the thread.
- R11: After reset, `req_valid`, `cache_blocked`, `out_valid`, `out_fault`, `out_count` and `drop_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A thread is selected for fetch this cycle |
| fetch_tid | input | TID_W | Selected thread |
| fetch_pc | input | ADDR_W | Fetch address of the selected thread |
| xlate_fault | input | 1 | Translation of this fetch faulted |
| intr_pending | input | 1 | Interrupt waiting to be taken |
| pred_taken | input | NINST | Predicted-taken flag per line instruction |
| quiesce | input | NINST | Quiesce marker per line instruction |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TID_W | Thread being squashed |
| req_valid | output | 1 | Line read valid |
| req_ready | input | 1 | Cache accepts the read |
| req_addr | output | ADDR_W | Block-aligned read address |
| req_tid | output | TID_W | Thread of the read |
| req_tag | output | TAG_W | Tag of the read |
| retry_pulse | input | 1 | Cache can take a refused read again |
| rsp_valid | input | 1 | Line response valid |
| rsp_tid | input | TID_W | Thread of the response |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_line | input | LINE_W | Full line data |
| cache_blocked | output | 1 | Global blocked flag |
| out_valid | output | FETCH_W | Decode slot valid bits |
| out_inst | output | FETCH_W*INST_W | Decode slot instructions |
| out_pc | output | ADDR_W | PC of slot 0 |
| out_tid | output | TID_W | Thread of the slots |
| out_fault | output | 1 | Slot 0 carries a fault no-op |
| out_count | output | OCNT_W | Number of valid slots |
| drop_cnt | output | CNT_W | Dropped-response counter |

## Verification
The bound checker watches several rules on every cycle. An occupied retry slot always coincides with the blocked flag. A new read never appears while the block is blocked or while the interrupt-and-aligned-PC condition holds. The drop counter only ever steps by one. Decode slots are always contiguous, and a fault cycle fills exactly one slot.

Some properties depend on a whole sequence of events and are shown only by the bench's scenarios: the reuse of a filled line, the cut-off rules across every start index and stop pattern, the resend of a parked read, the freeing of the slot by a squash, the dropping of a late response after a squash, and the trap that holds until a squash.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef enum logic [1:0] {
        TS_RUN        = 2'd0,
        TS_WAIT_RETRY = 2'd1,
        TS_WAIT_RESP  = 2'd2,
        TS_TRAP       = 2'd3
    } tstate_e;
endpackage

// File: rtl/fl_thread_ctl.sv
module fl_thread_ctl #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 128,
    parameter int TAG_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                squash_i,
    input  logic                issue_ok_i,
    input  logic                park_i,
    input  logic                retry_ok_i,
    input  logic                fault_i,
    input  logic [ADDR_W-1:0]   issue_addr_i,
    input  logic [TAG_W-1:0]    issue_tag_i,
    input  logic                rsp_ok_i,
    input  logic [LINE_W-1:0]   rsp_line_i,
    output fl_pkg::tstate_e     state_o,
    output logic [ADDR_W-1:0]   blk_o,
    output logic                lv_o,
    output logic [TAG_W-1:0]    tag_o,
    output logic [LINE_W-1:0]   line_o
);
    import fl_pkg::*;

    tstate_e st_q, st_d;

    // next-state process
    always_comb begin
        st_d = st_q;
        if (squash_i) begin
            st_d = TS_RUN;
        end else begin
            unique case (st_q)
                TS_RUN: begin
                    if (issue_ok_i)   st_d = TS_WAIT_RESP;
                    else if (park_i)  st_d = TS_WAIT_RETRY;
                    else if (fault_i) st_d = TS_TRAP;
                end
                TS_WAIT_RETRY: if (retry_ok_i) st_d = TS_WAIT_RESP;
                TS_WAIT_RESP:  if (rsp_ok_i)   st_d = TS_RUN;
                TS_TRAP:       st_d = TS_TRAP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TS_RUN;
        else        st_q <= st_d;
    end

    // line buffer: invalidated when a read is raised, filled on a match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_o  <= '0;
            lv_o   <= 1'b0;
            tag_o  <= '0;
            line_o <= '0;
        end else if (issue_ok_i || park_i) begin
            blk_o <= issue_addr_i;
            tag_o <= issue_tag_i;
            lv_o  <= 1'b0;
        end else if (rsp_ok_i) begin
            line_o <= rsp_line_i;
            lv_o   <= 1'b1;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/fl_retry_slot.sv
module fl_retry_slot #(
    parameter int TID_W  = 1,
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              park_i,
    input  logic [TID_W-1:0]  park_tid_i,
    input  logic [ADDR_W-1:0] park_addr_i,
    input  logic [TAG_W-1:0]  park_tag_i,
    input  logic              retry_pulse_i,
    input  logic              req_ready_i,
    input  logic              squash_i,
    input  logic [TID_W-1:0]  squash_tid_i,
    output logic              slot_v_o,
    output logic [TID_W-1:0]  slot_tid_o,
    output logic [ADDR_W-1:0] slot_addr_o,
    output logic [TAG_W-1:0]  slot_tag_o,
    output logic              blocked_o,
    output logic              resend_o
);
    logic owner_squash;
    assign owner_squash = squash_i && slot_v_o && (squash_tid_i == slot_tid_o);
    assign resend_o     = retry_pulse_i && slot_v_o && !owner_squash;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_v_o    <= 1'b0;
            slot_tid_o  <= '0;
            slot_addr_o <= '0;
            slot_tag_o  <= '0;
            blocked_o   <= 1'b0;
        end else begin
            if (park_i) begin
                slot_v_o    <= 1'b1;
                slot_tid_o  <= park_tid_i;
                slot_addr_o <= park_addr_i;
                slot_tag_o  <= park_tag_i;
                blocked_o   <= 1'b1;
            end else begin
                if (owner_squash || (resend_o && req_ready_i))
                    slot_v_o <= 1'b0;
                if (retry_pulse_i && !(resend_o && !req_ready_i))
                    blocked_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fl_extract.sv
module fl_extract #(
    parameter int NINST   = 4,
    parameter int INST_W  = 32,
    parameter int FETCH_W = 2,
    parameter int IDX_W   = 2,
    parameter int OCNT_W  = 2
) (
    input  logic [NINST*INST_W-1:0]   line_i,
    input  logic [IDX_W-1:0]          start_i,
    input  logic [NINST-1:0]          brk_i,
    input  logic [NINST-1:0]          qui_i,
    output logic [FETCH_W-1:0]        valid_o,
    output logic [FETCH_W*INST_W-1:0] inst_o,
    output logic [OCNT_W-1:0]         cnt_o
);
    always_comb begin
        logic halt;
        int   idx;
        halt    = 1'b0;
        valid_o = '0;
        inst_o  = '0;
        cnt_o   = '0;
        for (int k = 0; k < FETCH_W; k++) begin
            idx = int'(start_i) + k;
            if (!halt && idx < NINST) begin
                valid_o[k]                  = 1'b1;
                inst_o[k*INST_W +: INST_W]  = line_i[idx*INST_W +: INST_W];
                cnt_o                       = cnt_o + OCNT_W'(1);
                if (brk_i[idx] || qui_i[idx]) halt = 1'b1;
            end else begin
                halt = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fetch_line_unit.sv
module fetch_line_unit #(
    parameter int NTHREADS   = 2,
    parameter int ADDR_W     = 16,
    parameter int BLK_BYTES  = 16,
    parameter int INST_BYTES = 4,
    parameter int FETCH_W    = 2,
    parameter int TAG_W      = 4,
    parameter int CNT_W      = 8,
    localparam int OFF_W  = $clog2(BLK_BYTES),
    localparam int IB_W   = $clog2(INST_BYTES),
    localparam int NINST  = BLK_BYTES / INST_BYTES,
    localparam int IDX_W  = OFF_W - IB_W,
    localparam int INST_W = 8 * INST_BYTES,
    localparam int LINE_W = 8 * BLK_BYTES,
    localparam int TID_W  = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int OCNT_W = $clog2(FETCH_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fetch_valid,
    input  logic [TID_W-1:0]          fetch_tid,
    input  logic [ADDR_W-1:0]         fetch_pc,
    input  logic                      xlate_fault,
    input  logic                      intr_pending,
    input  logic [NINST-1:0]          pred_taken,
    input  logic [NINST-1:0]          quiesce,
    input  logic                      squash_valid,
    input  logic [TID_W-1:0]          squash_tid,
    output logic                      req_valid,
    input  logic                      req_ready,
    output logic [ADDR_W-1:0]         req_addr,
    output logic [TID_W-1:0]          req_tid,
    output logic [TAG_W-1:0]          req_tag,
    input  logic                      retry_pulse,
    input  logic                      rsp_valid,
    input  logic [TID_W-1:0]          rsp_tid,
    input  logic [TAG_W-1:0]          rsp_tag,
    input  logic [LINE_W-1:0]         rsp_line,
    output logic                      cache_blocked,
    output logic [FETCH_W-1:0]        out_valid,
    output logic [FETCH_W*INST_W-1:0] out_inst,
    output logic [ADDR_W-1:0]         out_pc,
    output logic [TID_W-1:0]          out_tid,
    output logic                      out_fault,
    output logic [OCNT_W-1:0]         out_count,
    output logic [CNT_W-1:0]          drop_cnt
);
    import fl_pkg::*;

    tstate_e           st   [NTHREADS];
    logic [ADDR_W-1:0] blk  [NTHREADS];
    logic [TAG_W-1:0]  otag [NTHREADS];
    logic [LINE_W-1:0] line [NTHREADS];
    logic [NTHREADS-1:0] lv;

    logic              slot_v, resend;
    logic [TID_W-1:0]  slot_tid;
    logic [ADDR_W-1:0] slot_addr;
    logic [TAG_W-1:0]  slot_tag;
    logic [TAG_W-1:0]  seq_q;

    logic [ADDR_W-1:0] aligned;
    logic hit, can_try, do_hit, do_fault, do_new, new_ok, new_park;
    logic retry_ok, rsp_match;

    logic [FETCH_W-1:0]        ex_valid;
    logic [FETCH_W*INST_W-1:0] ex_inst;
    logic [OCNT_W-1:0]         ex_cnt;

    // fetch decision
    assign aligned  = {fetch_pc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign hit      = lv[fetch_tid] && (blk[fetch_tid] == aligned);
    assign can_try  = fetch_valid && (st[fetch_tid] == TS_RUN) && !cache_blocked
                    && !(intr_pending && (fetch_pc[1:0] == 2'b00))
                    && !(squash_valid && (squash_tid == fetch_tid));
    assign do_hit   = can_try && hit;
    assign do_fault = can_try && !hit && xlate_fault;
    assign do_new   = can_try && !hit && !xlate_fault;
    assign new_ok   = do_new && req_ready;
    assign new_park = do_new && !req_ready;
    assign retry_ok = resend && req_ready;

    // request channel: parked read has the bus only while blocked
    assign req_valid = do_new || resend;
    assign req_addr  = resend ? slot_addr : aligned;
    assign req_tid   = resend ? slot_tid  : fetch_tid;
    assign req_tag   = resend ? slot_tag  : seq_q;

    assign rsp_match = rsp_valid && (st[rsp_tid] == TS_WAIT_RESP)
                     && (rsp_tag == otag[rsp_tid])
                     && !(squash_valid && (squash_tid == rsp_tid));

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        logic mine_f, mine_s, mine_r, mine_q;
        assign mine_f = (fetch_tid  == TID_W'(t));
        assign mine_s = squash_valid && (squash_tid == TID_W'(t));
        assign mine_r = (rsp_tid    == TID_W'(t));
        assign mine_q = (slot_tid   == TID_W'(t));

        fl_thread_ctl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_thr (
            .clk          (clk),
            .rst_n        (rst_n),
            .squash_i     (mine_s),
            .issue_ok_i   (new_ok && mine_f),
            .park_i       (new_park && mine_f),
            .retry_ok_i   (retry_ok && mine_q),
            .fault_i      (do_fault && mine_f),
            .issue_addr_i (aligned),
            .issue_tag_i  (seq_q),
            .rsp_ok_i     (rsp_match && mine_r),
            .rsp_line_i   (rsp_line),
            .state_o      (st[t]),
            .blk_o        (blk[t]),
            .lv_o         (lv[t]),
            .tag_o        (otag[t]),
            .line_o       (line[t])
        );
    end

    fl_retry_slot #(.TID_W(TID_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_slot (
        .clk           (clk),
        .rst_n         (rst_n),
        .park_i        (new_park),
        .park_tid_i    (fetch_tid),
        .park_addr_i   (aligned),
        .park_tag_i    (seq_q),
        .retry_pulse_i (retry_pulse),
        .req_ready_i   (req_ready),
        .squash_i      (squash_valid),
        .squash_tid_i  (squash_tid),
        .slot_v_o      (slot_v),
        .slot_tid_o    (slot_tid),
        .slot_addr_o   (slot_addr),
        .slot_tag_o    (slot_tag),
        .blocked_o     (cache_blocked),
        .resend_o      (resend)
    );

    fl_extract #(.NINST(NINST), .INST_W(INST_W), .FETCH_W(FETCH_W),
                 .IDX_W(IDX_W), .OCNT_W(OCNT_W)) u_ext (
        .line_i  (line[fetch_tid]),
        .start_i (fetch_pc[OFF_W-1:IB_W]),
        .brk_i   (pred_taken),
        .qui_i   (quiesce),
        .valid_o (ex_valid),
        .inst_o  (ex_inst),
        .cnt_o   (ex_cnt)
    );

    // sequence tag and drop counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            drop_cnt <= '0;
        end else begin
            if (do_new) seq_q <= seq_q + TAG_W'(1);
            if (rsp_valid && !rsp_match) drop_cnt <= drop_cnt + CNT_W'(1);
        end
    end

    // decode slot outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_inst  <= '0;
            out_pc    <= '0;
            out_tid   <= '0;
            out_fault <= 1'b0;
            out_count <= '0;
        end else if (do_hit) begin
            out_valid <= ex_valid;
            out_inst  <= ex_inst;
            out_pc    <= fetch_pc;
            out_tid   <= fetch_tid;
            out_fault <= 1'b0;
            out_count <= ex_cnt;
        end else if (do_fault) begin
            out_valid <= FETCH_W'(1);
            out_inst  <= '0;
            out_pc    <= fetch_pc;
            out_tid   <= fetch_tid;
            out_fault <= 1'b1;
            out_count <= OCNT_W'(1);
        end else begin
            out_valid <= '0;
            out_fault <= 1'b0;
            out_count <= '0;
        end
    end
endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
    parameter int FETCH_W = 2,
    parameter int OCNT_W  = 2,
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               slot_v,
    input logic               cache_blocked,
    input logic               req_valid,
    input logic               retry_pulse,
    input logic               intr_pending,
    input logic [ADDR_W-1:0]  fetch_pc,
    input logic [CNT_W-1:0]   drop_cnt,
    input logic [FETCH_W-1:0] out_valid,
    input logic               out_fault,
    input logic [OCNT_W-1:0]  out_count
);
    assert_slot_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_v |-> cache_blocked);

    assert_no_new_req_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !retry_pulse) |-> !cache_blocked);

    assert_no_new_req_intr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !retry_pulse && intr_pending) |-> (fetch_pc[1:0] != 2'b00));

    assert_drop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + CNT_W'(1)));

    assert_slots_contig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & (out_valid + FETCH_W'(1))) == '0));

    assert_fault_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_count == OCNT_W'(1) && out_valid == FETCH_W'(1)));
endmodule

bind fetch_line_unit fl_checker #(
    .FETCH_W (FETCH_W),
    .OCNT_W  (OCNT_W),
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_v        (slot_v),
    .cache_blocked (cache_blocked),
    .req_valid     (req_valid),
    .retry_pulse   (retry_pulse),
    .intr_pending  (intr_pending),
    .fetch_pc      (fetch_pc),
    .drop_cnt      (drop_cnt),
    .out_valid     (out_valid),
    .out_fault     (out_fault),
    .out_count     (out_count)
);

// File: tb/sim_fetch_line_unit.sv
`timescale 1ns/100ps
module sim_fetch_line_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_valid, xlate_fault, intr_pending;
    logic [0:0]   fetch_tid, squash_tid, req_tid, rsp_tid, out_tid;
    logic [15:0]  fetch_pc, req_addr, out_pc;
    logic [3:0]   pred_taken, quiesce, req_tag, rsp_tag;
    logic         squash_valid, req_valid, req_ready, retry_pulse, rsp_valid;
    logic [127:0] rsp_line;
    logic         cache_blocked, out_fault;
    logic [1:0]   out_valid, out_count;
    logic [63:0]  out_inst;
    logic [7:0]   drop_cnt;

    int nchk = 0, nerr = 0;
    int tag0, tag1, tag2;

    always #2.5 clk = ~clk;

    fetch_line_unit u0 (.*);

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mkline(input int base);
        logic [127:0] l;
        for (int j = 0; j < 4; j++) l[j*32 +: 32] = 32'hA500_0000 | 32'(base + j*4);
        return l;
    endfunction

    task automatic idle();
        fetch_valid = 0; fetch_tid = 0; fetch_pc = 0; xlate_fault = 0;
        intr_pending = 0; pred_taken = 0; quiesce = 0; squash_valid = 0;
        squash_tid = 0; req_ready = 0; retry_pulse = 0; rsp_valid = 0;
        rsp_tid = 0; rsp_tag = 0; rsp_line = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic fetch(input int tid, input int pc, input bit rdy);
        fetch_valid = 1; fetch_tid = 1'(tid); fetch_pc = 16'(pc); req_ready = rdy;
        #1;
    endtask

    task automatic respond(input int tid, input int tag, input int base);
        rsp_valid = 1; rsp_tid = 1'(tid); rsp_tag = 4'(tag); rsp_line = mkline(base);
        step();
    endtask

    task automatic squash(input int tid);
        squash_valid = 1; squash_tid = 1'(tid);
        step();
    endtask

    initial begin
        #(200000 * 5);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R11 reset state
        chk("R11", "req_valid", req_valid, 0);
        chk("R11", "blocked", cache_blocked, 0);
        chk("R11", "out_valid", out_valid, 0);
        chk("R11", "out_fault", out_fault, 0);
        chk("R11", "out_count", out_count, 0);
        chk("R11", "drop_cnt", drop_cnt, 0);

        // R1 R3 miss on thread 0
        fetch(0, 'h0104, 1);
        chk("R3", "req_valid on miss", req_valid, 1);
        chk("R1", "aligned addr", req_addr, 'h0100);
        chk("R3", "req_tid", req_tid, 0);
        tag0 = req_tag;
        step();
        fetch(0, 'h0104, 1);
        chk("R3", "no second read while waiting", req_valid, 0);
        step();
        chk("R3", "no slots while waiting", out_valid, 0);
        respond(0, tag0, 'h0100);
        chk("R6", "matching response kept", drop_cnt, 0);

        // R2 R8 sweep: every start index and every stop pattern
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 16; m++) begin
                int ec;
                pred_taken = 4'(m);
                fetch(0, 'h0100 + s*4, 1);
                if (m == 0) chk("R2", "no read on hit", req_valid, 0);
                step();
                ec = 0;
                for (int k = 0; k < 2; k++) begin
                    if (s + k >= 4) break;
                    ec++;
                    if (m[s+k]) break;
                end
                chk("R8", "count", out_count, ec);
                chk("R8", "valid mask", out_valid, (1 << ec) - 1);
                chk("R2", "slot0 inst", out_inst[31:0], 32'hA500_0100 + s*4);
                if (ec == 2) chk("R8", "slot1 inst", out_inst[63:32], 32'hA500_0104 + s*4);
            end
        end
        // R8 quiesce stops
        quiesce = 4'b0001; fetch(0, 'h0100, 1); step();
        chk("R8", "quiesce at first", out_count, 1);
        quiesce = 4'b0100; fetch(0, 'h0104, 1); step();
        chk("R8", "quiesce beyond width", out_count, 2);
        chk("R2", "out_pc", out_pc, 'h0104);

        // R6 stray response for a running thread
        respond(1, 5, 'h0900);
        chk("R6", "stray drop", drop_cnt, 1);

        // R4 park on refusal
        fetch(1, 'h0208, 0);
        chk("R4", "req raised", req_valid, 1);
        tag1 = req_tag;
        step();
        chk("R4", "blocked set", cache_blocked, 1);
        // R7 blocked refuses miss and hit
        fetch(0, 'h0300, 1);
        chk("R7", "no read while blocked", req_valid, 0);
        step();
        fetch(0, 'h0100, 1); step();
        chk("R7", "no hit while blocked", out_valid, 0);

        // R5 retry resend
        retry_pulse = 1; req_ready = 1; #1;
        chk("R5", "resend valid", req_valid, 1);
        chk("R5", "resend addr", req_addr, 'h0200);
        chk("R5", "resend tid", req_tid, 1);
        chk("R5", "resend tag", req_tag, tag1);
        step();
        chk("R5", "blocked cleared", cache_blocked, 0);
        respond(1, tag1, 'h0200);
        fetch(1, 'h0208, 1); step();
        chk("R5", "filled line count", out_count, 2);
        chk("R5", "filled line inst", out_inst[31:0], 32'hA500_0208);
        chk("R5", "out_tid", out_tid, 1);

        // R10 squash frees retry slot
        fetch(1, 'h0240, 0); step();
        chk("R4", "blocked again", cache_blocked, 1);
        squash(1);
        chk("R10", "blocked held after squash", cache_blocked, 1);
        retry_pulse = 1; req_ready = 1; #1;
        chk("R10", "slot freed no resend", req_valid, 0);
        step();
        chk("R5", "empty slot retry clears", cache_blocked, 0);

        // R7 interrupt
        intr_pending = 1; fetch(0, 'h0300, 1);
        chk("R7", "intr aligned pc refused", req_valid, 0);
        step();
        chk("R7", "intr no slots", out_valid, 0);
        intr_pending = 1; fetch(0, 'h0302, 1);
        chk("R7", "intr odd pc allowed", req_valid, 1);
        chk("R1", "aligned addr odd pc", req_addr, 'h0300);
        tag2 = req_tag;
        step();

        // R10 squash drops outstanding miss
        squash(0);
        respond(0, tag2, 'h0300);
        chk("R10", "late response dropped", drop_cnt, 2);
        fetch(0, 'h0300, 1);
        chk("R10", "line not filled, new read", req_valid, 1);
        step();
        squash(0);

        // R9 fault
        xlate_fault = 1; fetch(0, 'h0400, 1);
        chk("R9", "no read on fault", req_valid, 0);
        step();
        chk("R9", "one slot", out_valid, 1);
        chk("R9", "fault flag", out_fault, 1);
        chk("R9", "nop inst", out_inst[31:0], 0);
        chk("R9", "count", out_count, 1);
        fetch(0, 'h0400, 1);
        chk("R9", "trapped no read", req_valid, 0);
        step();
        chk("R9", "trapped no slots", out_valid, 0);
        squash(0);
        fetch(0, 'h0400, 1);
        chk("R10", "runs after squash", req_valid, 1);
        step();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule